// File: doc/BRIEF.md
# Sprite Page DMA Copier

This block copies one 256-byte page of work RAM into the data port of the sprite attribute memory. A CPU write of a page number to a fixed trigger address starts it. While the copy runs the block stalls the CPU and takes over the shared bus. It moves each byte with a read from work RAM followed by a write to the sprite data port.

The low three bits of the written value select one of eight 256-byte pages in the 2 KiB work RAM. The source address is therefore never above 0x07FF. The block does not model the sprite memory or the work RAM. It drives bus address, direction and write data, and it samples the read data the bus returns during each read cycle.

Top module: `sprite_dma`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cpu_stall`, `bus_own`, `bus_we` and `xfer_done` are all 0.
- R2: A cycle with `cpu_wr`=1 and `cpu_addr`=0x4014, seen at a clock edge while the block is idle, makes `cpu_stall` and `bus_own` 1 from that edge onward. The first bus cycle is a read (`bus_we`=0).
- R3: The read for byte index b (0..255) uses `bus_addr` = (`cpu_wdata` AND 7) × 0x100 + b. Bits 7..3 of the written value have no effect on any address.
- R4: Bus cycles strictly alternate read, write, read, write. Every write cycle has `bus_addr`=0x2004, and its `bus_wdata` equals the `bus_rdata` returned in the read cycle just before it.
- R5: A transfer is exactly 256 read/write pairs (512 bus cycles), with the byte index rising from 0 to 255.
- R6: `cpu_stall` stays 1 from the cycle after the trigger through the final write cycle, and it is 0 in the cycle after that.
- R7: `xfer_done` is 1 for exactly one cycle: the cycle right after the final write.
- R8: A trigger write that arrives while a transfer is active is ignored. The running transfer keeps its page, its sequence and its length.
- R9: A write to any other address, or the trigger address present with `cpu_wr`=0, does not start a transfer.
- R10: Every read cycle's `bus_addr` lies in 0x0000..0x07FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data (page number in bits 2..0) |
| bus_rdata | input | 8 | Read data returned by the bus |
| cpu_stall | output | 1 | Holds the CPU off the bus while copying |
| bus_own | output | 1 | Block drives the bus this cycle |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| xfer_done | output | 1 | One-cycle pulse after the final write |

## Verification
The assertions assume that `bus_rdata` is valid in the same cycle as a read address. They also assume that the CPU issues no trigger during reset. The bench meets both assumptions: a work-RAM model answers combinationally to `bus_addr`, and it moves the CPU strobe only on falling edges after reset is released. A trigger injected in the middle of a copy checks that the assertions on alternation, destination and address window hold even when the CPU keeps writing while it is stalled.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } dma_state_e;
endpackage

// File: rtl/sprite_dma_trig.sv
module sprite_dma_trig #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEL_W = 3,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              idle,
  output logic              start,
  output logic [SEL_W-1:0]  page_sel
);
  // Only the low bits choose the page; the rest are deliberately dropped.
  logic unused_hi;
  assign unused_hi = ^cpu_wdata[DATA_W-1:SEL_W];

  assign start    = cpu_wr && (cpu_addr == TRIG_ADDR) && idle;
  assign page_sel = cpu_wdata[SEL_W-1:0];
endmodule

// File: rtl/sprite_dma_seq.sv
module sprite_dma_seq
  import sprite_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       last,
  output dma_state_e state,
  output dma_state_e nxt,
  output logic       cpu_stall,
  output logic       bus_own,
  output logic       bus_we,
  output logic       xfer_done
);
  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start) nxt = ST_RD;
      ST_RD:   nxt = ST_WR;
      ST_WR:   nxt = last ? ST_IDLE : ST_RD;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cpu_stall <= 1'b0;
      bus_own   <= 1'b0;
      bus_we    <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      state     <= nxt;
      cpu_stall <= (nxt != ST_IDLE);
      bus_own   <= (nxt != ST_IDLE);
      bus_we    <= (nxt == ST_WR);
      xfer_done <= (state == ST_WR) && last;
    end
  end

  // R4
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_own && !bus_we) |=> (bus_own && bus_we));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  // R6
  stall_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_stall) |-> xfer_done);
endmodule

// File: rtl/sprite_dma_path.sv
module sprite_dma_path
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEL_W = 3,
  parameter int BYTES = 256,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  page_sel,
  input  dma_state_e        state,
  input  dma_state_e        nxt,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              last,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata
);
  localparam int CNT_W = $clog2(BYTES);
  localparam int RAM_W = SEL_W + CNT_W;

  logic [SEL_W-1:0] page_q, page_nxt;
  logic [CNT_W-1:0] idx_q, idx_nxt;
  logic [RAM_W-1:0] src_nxt;

  always_comb begin
    page_nxt = page_q;
    idx_nxt  = idx_q;
    if (start) begin
      page_nxt = page_sel;
      idx_nxt  = '0;
    end else if (state == ST_WR) begin
      idx_nxt = idx_q + CNT_W'(1);
    end
  end

  assign src_nxt = {page_nxt, idx_nxt};
  assign last    = (idx_q == CNT_W'(BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q    <= '0;
      idx_q     <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      page_q <= page_nxt;
      idx_q  <= idx_nxt;
      case (nxt)
        ST_RD:   bus_addr <= ADDR_W'(src_nxt);
        ST_WR:   bus_addr <= DEST_ADDR;
        default: bus_addr <= '0;
      endcase
      bus_wdata <= (nxt == ST_WR) ? bus_rdata : '0;
    end
  end

  // R4
  dest_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR) |-> (bus_addr == DEST_ADDR));

  // R10
  src_window_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD) |-> (bus_addr < ADDR_W'(1 << RAM_W)));
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEL_W = 3,
  parameter int BYTES = 256,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_stall,
  output logic              bus_own,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              xfer_done
);
  dma_state_e       state, nxt;
  logic             start, last;
  logic [SEL_W-1:0] page_sel;

  sprite_dma_trig #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .TRIG_ADDR(TRIG_ADDR)
  ) u_trig (
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .idle(state == ST_IDLE), .start(start), .page_sel(page_sel)
  );

  sprite_dma_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .last(last),
    .state(state), .nxt(nxt), .cpu_stall(cpu_stall), .bus_own(bus_own),
    .bus_we(bus_we), .xfer_done(xfer_done)
  );

  sprite_dma_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .BYTES(BYTES),
    .DEST_ADDR(DEST_ADDR)
  ) u_path (
    .clk(clk), .rst(rst), .start(start), .page_sel(page_sel),
    .state(state), .nxt(nxt), .bus_rdata(bus_rdata), .last(last),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_own && cpu_wr && cpu_addr == TRIG_ADDR && bus_we && !last) |=> (bus_own && !bus_we));
endmodule

// File: tb/test_sprite_dma.sv
module test_sprite_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        cpu_stall, bus_own, bus_we, xfer_done;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  typedef struct { logic we; logic [15:0] addr; logic [7:0] data; } item_t;
  item_t sb_q[$];

  logic [7:0] ram [0:2047];

  always #2 clk = ~clk;

  assign bus_rdata = bus_own ? ram[bus_addr[10:0]] : 8'h00;

  sprite_dma i_sprite_dma (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .bus_rdata(bus_rdata), .cpu_stall(cpu_stall),
    .bus_own(bus_own), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .xfer_done(xfer_done)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitor: pops expected bus cycles as the design issues them
  always @(negedge clk) begin
    if (!rst && bus_own) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R5 extra bus cycle", int'(bus_addr), 0);
      end else begin
        item_t e;
        e = sb_q.pop_front();
        if (e.we) begin
          chk(bus_we === 1'b1 && bus_addr === e.addr, "R4 write cycle addr",
              int'(bus_addr), int'(e.addr));
          chk(bus_wdata === e.data, "R4 write data", int'(bus_wdata), int'(e.data));
        end else begin
          chk(bus_we === 1'b0 && bus_addr === e.addr, "R3 read cycle addr",
              int'(bus_addr), int'(e.addr));
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", cycles, 100000);
      summary();
    end
  end

  task automatic push_expected(input logic [7:0] v);
    for (int b = 0; b < 256; b++) begin
      logic [15:0] src;
      src = {5'b0, v[2:0], 8'(b)};
      sb_q.push_back('{1'b0, src, 8'h00});
      sb_q.push_back('{1'b1, 16'h2004, ram[src[10:0]]});
    end
  endtask

  task automatic pulse_write(input logic [15:0] a, input logic [7:0] v, input logic wr);
    @(negedge clk);
    cpu_wr = wr; cpu_addr = a; cpu_wdata = v;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
  endtask

  // Full transfer; inj>0 injects a second trigger at that cycle (R8)
  task automatic run_dma(input logic [7:0] v, input int inj, input logic [7:0] inj_v);
    push_expected(v);
    pulse_write(16'h4014, v, 1'b1);
    chk(cpu_stall === 1'b1 && bus_own === 1'b1 && bus_we === 1'b0, "R2 start",
        int'({cpu_stall, bus_own, bus_we}), 6);
    for (int k = 1; k < 512; k++) begin
      @(negedge clk);
      if (k == inj + 1) begin cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0; end
      if (cpu_stall !== 1'b1 || xfer_done !== 1'b0)
        chk(1'b0, "R6 stall held", int'({cpu_stall, xfer_done}), 2);
      if (k == inj) begin cpu_wr = 1'b1; cpu_addr = 16'h4014; cpu_wdata = inj_v; end
    end
    chk(cpu_stall === 1'b1, "R6 stall during final write", int'(cpu_stall), 1);
    @(negedge clk);
    chk(cpu_stall === 1'b0 && bus_own === 1'b0, "R6 release", int'({cpu_stall, bus_own}), 0);
    chk(xfer_done === 1'b1, "R7 done pulse", int'(xfer_done), 1);
    @(negedge clk);
    chk(xfer_done === 1'b0, "R7 done single", int'(xfer_done), 0);
    chk(sb_q.size() == 0, "R5 all 512 cycles seen", sb_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) ram[i] = 8'(i * 37 + (i >> 8) * 11 + 5);
    repeat (3) @(negedge clk);
    chk(cpu_stall === 1'b0 && bus_own === 1'b0 && bus_we === 1'b0 && xfer_done === 1'b0,
        "R1 reset state", int'({cpu_stall, bus_own, bus_we, xfer_done}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_stall === 1'b0 && bus_own === 1'b0 && xfer_done === 1'b0,
        "R1 after reset", int'({cpu_stall, bus_own, xfer_done}), 0);

    run_dma(8'h00, 0, 8'h00);
    run_dma(8'h07, 0, 8'h00);
    run_dma(8'hFD, 0, 8'h00);          // R3 upper bits ignored, page 5
    run_dma(8'h02, 300, 8'h06);        // R8 mid-transfer trigger ignored

    // R9 other address, and trigger address without strobe
    pulse_write(16'h4015, 8'h03, 1'b1);
    chk(cpu_stall === 1'b0 && bus_own === 1'b0, "R9 other address", int'({cpu_stall, bus_own}), 0);
    pulse_write(16'h4014, 8'h03, 1'b0);
    chk(cpu_stall === 1'b0 && bus_own === 1'b0, "R9 no strobe", int'({cpu_stall, bus_own}), 0);
    repeat (3) @(negedge clk);
    chk(bus_own === 1'b0 && sb_q.size() == 0, "R9 still idle", int'(bus_own), 0);
    // R10 covered by read addresses of page 7 staying below 0x0800
    summary();
  end
endmodule